// File: doc/BRIEF.md
# Register-mapped serial port with transmit and receive queues

This block is an asynchronous serial port that a processor drives through a small 32-bit register window. The window has a simple write strobe, a read strobe and a byte address. Through it software sets the bit rate, turns the transmitter and receiver on and off, pulses a flush of either direction, watches a status word, and moves characters through one shared data register. A write to that register queues a byte for sending. A read takes the oldest byte that has arrived.

Characters on the line are fixed at eight data bits, least significant bit first, with no parity and one stop bit. The bit time comes from two counters in series. The first counter divides the clock into ticks of `bgen` cycles. The second counts `bdiv + 1` ticks per bit, so one bit lasts `bgen * (bdiv + 1)` clock cycles. The receiver waits half a bit after a falling edge and confirms that the start bit is still low before it takes any data bits.

Top module: `mmio_uart`

## Requirements
- R1: Register offsets (byte address): control 0x00, mode 0x04, tick divisor 0x18, status 0x2C, data 0x30, bit divisor 0x34. Control reads back bits [8:0], mode bits [10:0], tick divisor bits [15:0] and bit divisor bits [7:0]. All other bits of these registers, and every other address, read as zero.
- R2: After reset, control reads 0x000, mode reads 0x000, tick divisor reads 0x028B, bit divisor reads 0x0F and status reads 0x00A.
- R3: Status bit 1 is set while the receive queue is empty. Bit 2 is set while it is full. Bit 3 is set while the transmit queue is empty. Bit 4 is set while it is full. Bit 11 is set while a character is on the line. All other status bits are zero.
- R4: The idle line is high. A frame is one low start bit, then data bits 0 to 7, then one high stop bit. Every bit after the start bit lasts exactly `bgen*(bdiv+1)` clock cycles. The start bit may be up to one tick shorter. A tick divisor below 2 stops the bit clock.
- R5: Status bit 11 rises when a start bit begins. It stays high without a gap across back-to-back queued characters, and falls at the end of the last stop bit.
- R6: Writing the data register queues bits [7:0] for transmission. Reading it returns the oldest received byte in bits [7:0] and removes it from the queue. Bytes come out in arrival order.
- R7: The transmit queue holds 64 bytes. A data write while it is full is dropped.
- R8: The receive queue holds 64 bytes. A character that completes while it is full is discarded.
- R9: A low pulse on the receive line that has ended by the middle of the start bit is rejected and queues nothing.
- R10: Control bit 0 flushes the receive queue and receive state, and control bit 1 flushes the transmit queue and transmit state. The line returns high and bit 11 falls. Both bits read zero from the second cycle after the write.
- R11: With control bit 4 clear, queued bytes stay queued and the line stays high. With control bit 2 clear, the receiver ignores the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; removes a byte when addressing data |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The bench checks that a byte written at the moment the transmit queue is full is lost, and that the 65th character sent into a full receive queue is lost. A design that wrapped a pointer instead would overwrite the oldest entry, and the readback order would fail. It measures how long the active flag stays high across two back-to-back characters; a transmitter that passed through idle between frames would show a one-cycle drop and a shorter count. It applies a two-cycle low glitch to the receive line, and it flushes the transmitter in the middle of a frame while looping the line back. A receiver that skipped the mid-start check, or a flush that left shift state behind, would then leave a stray byte in the receive queue.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_BGEN = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h2C;
  localparam logic [7:0] OFS_DATA = 8'h30;
  localparam logic [7:0] OFS_BDIV = 8'h34;

  localparam int CTL_RXRST = 0;
  localparam int CTL_TXRST = 1;
  localparam int CTL_RXEN  = 2;
  localparam int CTL_TXEN  = 4;

  localparam int ST_RXEMPTY = 1;
  localparam int ST_RXFULL  = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_TXFULL  = 4;
  localparam int ST_TXACT   = 11;

  localparam int CTRL_W = 9;
  localparam int MODE_W = 11;
  localparam int STAT_W = 12;
  localparam int BGEN_W = 16;
  localparam int BDIV_W = 8;
  localparam int CHAR_W = 8;

  localparam logic [BGEN_W-1:0] BGEN_RST = 16'h028B;
  localparam logic [BDIV_W-1:0] BDIV_RST = 8'h0F;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_nx(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_nx(wptr_q);
      if (do_pop)  rptr_q <= ptr_nx(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wptr_q)));

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/mmio_uart_baud.sv
module mmio_uart_baud #(
  parameter int BGEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BGEN_W-1:0] bgen_i,
  output logic              tick_o
);
  logic [BGEN_W-1:0] cnt_q;
  logic              tick_q;
  logic              run;

  // divisors 0 and 1 park the bit clock
  assign run    = (bgen_i >= BGEN_W'(2));
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= bgen_i - BGEN_W'(1)) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + BGEN_W'(1);
      tick_q <= 1'b0;
    end
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx #(
  parameter int CHAR_W = 8,
  parameter int BDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic              q_empty_i,
  input  logic [CHAR_W-1:0] q_data_i,
  output logic              q_pop_o,
  output logic              txd_o,
  output logic              active_o
);
  localparam int FRAME_W = CHAR_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BDIV_W-1:0]  tcnt_q;
  logic               active_q, txd_q;
  logic               bit_end, last_end, load;

  assign bit_end  = active_q && tick_i && (tcnt_q >= bdiv_i);
  assign last_end = bit_end && (idx_q == IDX_W'(FRAME_W - 1));
  // reload straight out of the stop bit so active never dips between frames
  assign load     = !flush_i && en_i && !q_empty_i && (!active_q || last_end);
  assign q_pop_o  = load;
  assign txd_o    = txd_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '1;
      idx_q    <= '0;
      tcnt_q   <= '0;
      active_q <= 1'b0;
      txd_q    <= 1'b1;
    end else if (flush_i) begin
      idx_q    <= '0;
      tcnt_q   <= '0;
      active_q <= 1'b0;
      txd_q    <= 1'b1;
    end else if (load) begin
      sh_q     <= {1'b1, q_data_i, 1'b0};
      idx_q    <= '0;
      tcnt_q   <= '0;
      active_q <= 1'b1;
      txd_q    <= 1'b0;
    end else if (last_end) begin
      active_q <= 1'b0;
      txd_q    <= 1'b1;
    end else if (bit_end) begin
      tcnt_q <= '0;
      idx_q  <= idx_q + IDX_W'(1);
      txd_q  <= sh_q[idx_q + IDX_W'(1)];
    end else if (active_q && tick_i) begin
      tcnt_q <= tcnt_q + BDIV_W'(1);
    end
  end

  // R4
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> txd_o);

  // R11
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !en_i) |=> !active_o);
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int BDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic              rxd_i,
  output logic              push_o,
  output logic [CHAR_W-1:0] data_o
);
  localparam int HW    = BDIV_W + 1;
  localparam int BIT_W = $clog2(CHAR_W);

  rx_state_e         state_q;
  logic [2:0]        sync_q;
  logic [BDIV_W-1:0] cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CHAR_W-1:0] sh_q;
  logic              push_q;
  logic [HW-1:0]     half_w, cnt_nx;
  logic              line, fall;

  assign line   = sync_q[1];
  assign fall   = sync_q[2] && !sync_q[1];
  assign half_w = (HW'(bdiv_i) + HW'(1)) >> 1;
  assign cnt_nx = HW'(cnt_q) + HW'(1);
  assign push_o = push_q;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[1:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      push_q  <= 1'b0;
    end else if (flush_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      push_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (en_i && fall) state_q <= RX_START;
        end
        RX_START: if (tick_i) begin
          if (cnt_nx >= half_w) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            // start bit must still be low at mid-bit
            state_q <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + BDIV_W'(1);
          end
        end
        RX_DATA: if (tick_i) begin
          if (cnt_q >= bdiv_i) begin
            cnt_q <= '0;
            sh_q  <= {line, sh_q[CHAR_W-1:1]};
            bit_q <= bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(CHAR_W - 1)) state_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + BDIV_W'(1);
          end
        end
        RX_STOP: if (tick_i) begin
          if (cnt_q >= bdiv_i) begin
            cnt_q   <= '0;
            push_q  <= 1'b1;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + BDIV_W'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // R6
  push_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  // R9
  glitch_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && !flush_i && line) |=> !push_o);
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [MODE_W-1:0] mode_q;
  logic [BGEN_W-1:0] bgen_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic [STAT_W-1:0] stat;

  logic ctrl_wr, mode_wr, bgen_wr, bdiv_wr, data_wr, data_rd;
  logic tick;
  logic tx_empty, tx_full, tx_pop, tx_active;
  logic rx_empty, rx_full, rx_push;
  logic [CHAR_W-1:0] tx_head, rx_char, rx_head;
  logic unused_wdata;

  assign ctrl_wr = wr_i && (addr_i == OFS_CTRL);
  assign mode_wr = wr_i && (addr_i == OFS_MODE);
  assign bgen_wr = wr_i && (addr_i == OFS_BGEN);
  assign bdiv_wr = wr_i && (addr_i == OFS_BDIV);
  assign data_wr = wr_i && (addr_i == OFS_DATA);
  assign data_rd = rd_i && (addr_i == OFS_DATA);
  assign unused_wdata = ^wdata_i[31:BGEN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      bgen_q <= BGEN_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= wdata_i[CTRL_W-1:0];
      end else begin
        ctrl_q[CTL_RXRST] <= 1'b0;
        ctrl_q[CTL_TXRST] <= 1'b0;
      end
      if (mode_wr) mode_q <= wdata_i[MODE_W-1:0];
      if (bgen_wr) bgen_q <= wdata_i[BGEN_W-1:0];
      if (bdiv_wr) bdiv_q <= wdata_i[BDIV_W-1:0];
    end
  end

  mmio_uart_baud #(.BGEN_W(BGEN_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bgen_i (bgen_q),
    .tick_o (tick)
  );

  mmio_uart_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CTL_TXRST]),
    .push_i  (data_wr),
    .wdata_i (wdata_i[CHAR_W-1:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  mmio_uart_tx #(.CHAR_W(CHAR_W), .BDIV_W(BDIV_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (ctrl_q[CTL_TXRST]),
    .en_i      (ctrl_q[CTL_TXEN]),
    .tick_i    (tick),
    .bdiv_i    (bdiv_q),
    .q_empty_i (tx_empty),
    .q_data_i  (tx_head),
    .q_pop_o   (tx_pop),
    .txd_o     (txd_o),
    .active_o  (tx_active)
  );

  mmio_uart_rx #(.CHAR_W(CHAR_W), .BDIV_W(BDIV_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CTL_RXRST]),
    .en_i    (ctrl_q[CTL_RXEN]),
    .tick_i  (tick),
    .bdiv_i  (bdiv_q),
    .rxd_i   (rxd_i),
    .push_o  (rx_push),
    .data_o  (rx_char)
  );

  mmio_uart_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CTL_RXRST]),
    .push_i  (rx_push),
    .wdata_i (rx_char),
    .pop_i   (data_rd),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  always_comb begin
    stat             = '0;
    stat[ST_RXEMPTY] = rx_empty;
    stat[ST_RXFULL]  = rx_full;
    stat[ST_TXEMPTY] = tx_empty;
    stat[ST_TXFULL]  = tx_full;
    stat[ST_TXACT]   = tx_active;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      OFS_MODE: rdata_o[MODE_W-1:0] = mode_q;
      OFS_BGEN: rdata_o[BGEN_W-1:0] = bgen_q;
      OFS_BDIV: rdata_o[BDIV_W-1:0] = bdiv_q;
      OFS_STAT: rdata_o[STAT_W-1:0] = stat;
      OFS_DATA: rdata_o[CHAR_W-1:0] = rx_empty ? '0 : rx_head;
      default:  rdata_o = '0;
    endcase
  end

  // R10
  ctrl_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTL_TXRST] && !ctrl_wr) |=> !ctrl_q[CTL_TXRST]);

  // R10
  rx_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTL_RXRST] && !ctrl_wr) |=> !ctrl_q[CTL_RXRST]);

  // R5
  line_low_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> tx_active);
endmodule

// File: tb/mmio_uart_tb.sv
module mmio_uart_tb;
  import mmio_uart_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        loop_en = 1'b0, drv_rxd = 1'b1;
  logic        txd, rxd;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h3C, 8'hC3};

  always #5 clk = ~clk;
  assign rxd = loop_en ? txd : drv_rxd;

  mmio_uart u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); drv_rxd = 1'b0; idle(10);
    for (int i = 0; i < 8; i++) begin drv_rxd = b[i]; idle(10); end
    drv_rxd = 1'b1; idle(12);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int lows, act;
    idle(3); rst_n = 1'b1; idle(2);

    // R2 reset state, R3 status encoding
    reg_rd(OFS_CTRL, v); chk("R2 ctrl", v, 32'h0);
    reg_rd(OFS_MODE, v); chk("R2 mode", v, 32'h0);
    reg_rd(OFS_BGEN, v); chk("R2 bgen", v, 32'h028B);
    reg_rd(OFS_BDIV, v); chk("R2 bdiv", v, 32'h0F);
    reg_rd(OFS_STAT, v); chk("R3 reset status", v, 32'h00A);

    // R1 masks and unmapped
    reg_wr(OFS_MODE, 32'hFFFF_FFFF); reg_rd(OFS_MODE, v); chk("R1 mode mask", v, 32'h7FF);
    reg_wr(OFS_BGEN, 32'hFFFF_1234); reg_rd(OFS_BGEN, v); chk("R1 bgen mask", v, 32'h1234);
    reg_wr(OFS_BDIV, 32'h0000_ABCD); reg_rd(OFS_BDIV, v); chk("R1 bdiv mask", v, 32'hCD);
    reg_wr(OFS_CTRL, 32'hFFFF_FFFC); reg_rd(OFS_CTRL, v); chk("R1 ctrl mask", v, 32'h1FC);
    reg_rd(8'h08, v); chk("R1 unmapped", v, 32'h0);
    reg_wr(OFS_CTRL, 32'h3); reg_rd(OFS_CTRL, v); chk("R10 self clear", v, 32'h0);

    // 10-cycle bit: tick 2, 5 ticks per bit
    reg_wr(OFS_BGEN, 32'd2); reg_wr(OFS_BDIV, 32'd4);
    loop_en = 1'b1;
    reg_wr(OFS_CTRL, 32'h14);

    // R4 frame shape
    reg_wr(OFS_DATA, 32'hA5);
    lows = 0;
    while (txd !== 1'b0 && lows < 50) begin @(negedge clk); lows++; end
    for (int k = 0; k < 10; k++) begin
      logic expb;
      idle(k == 0 ? 5 : 10);
      expb = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : VEC[0][0] | 8'hA5 >> (k - 1);
      expb = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : ((8'hA5 >> (k - 1)) & 8'h01) != 0;
      chk($sformatf("R4 bit %0d", k), {31'b0, txd}, {31'b0, expb});
    end
    idle(10);
    reg_rd(OFS_STAT, v); chk("R5 active low after stop", v & 32'h800, 32'h0);
    reg_rd(OFS_DATA, v); chk("R6 loopback A5", v, 32'hA5);

    // R5 contiguous active across two frames
    reg_wr(OFS_CTRL, 32'h04);
    reg_wr(OFS_DATA, 32'h5A); reg_wr(OFS_DATA, 32'hC3);
    @(negedge clk); addr = OFS_CTRL; wdata = 32'h14; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = OFS_STAT;
    act = 0; lows = 0;
    while (lows < 400) begin
      #1;
      if (rdata[ST_TXACT]) act++;
      else if (act > 0) break;
      @(negedge clk); lows++;
    end
    chk("R5 active span in 198..201", {31'b0, (act >= 198 && act <= 201)}, 32'h1);
    idle(20);
    reg_rd(OFS_DATA, v); chk("R6 order first", v, 32'h5A);
    reg_rd(OFS_DATA, v); chk("R6 order second", v, 32'hC3);
    reg_rd(OFS_DATA, v); chk("R6 empty read zero", v, 32'h0);

    // R6 vector table through loopback
    for (int i = 0; i < 8; i++) begin
      reg_wr(OFS_DATA, {24'b0, VEC[i]});
      idle(115);
      reg_rd(OFS_DATA, v); chk($sformatf("R6 vec %0d", i), v, {24'b0, VEC[i]});
    end
    reg_rd(OFS_STAT, v); chk("R3 idle status", v, 32'h00A);

    // R11 transmitter off holds queue
    reg_wr(OFS_CTRL, 32'h04);
    reg_wr(OFS_DATA, 32'h11); reg_wr(OFS_DATA, 32'h22); reg_wr(OFS_DATA, 32'h33);
    lows = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R11 line stays high", lows, 0);
    reg_rd(OFS_STAT, v); chk("R11 queue kept", v, 32'h002);
    reg_wr(OFS_CTRL, 32'h14); idle(350);
    reg_rd(OFS_DATA, v); chk("R11 released 11", v, 32'h11);
    reg_rd(OFS_DATA, v); chk("R11 released 22", v, 32'h22);
    reg_rd(OFS_DATA, v); chk("R11 released 33", v, 32'h33);

    // R11 receiver off
    reg_wr(OFS_CTRL, 32'h10); reg_wr(OFS_DATA, 32'h77); idle(150);
    reg_rd(OFS_STAT, v); chk("R11 rx ignores line", v & 32'h2, 32'h2);

    // R10 transmit flush of queued bytes
    reg_wr(OFS_CTRL, 32'h04);
    reg_wr(OFS_DATA, 32'h01); reg_wr(OFS_DATA, 32'h02); reg_wr(OFS_DATA, 32'h03);
    reg_wr(OFS_CTRL, 32'h06);
    reg_rd(OFS_CTRL, v); chk("R10 ctrl after txrst", v, 32'h004);
    reg_rd(OFS_STAT, v); chk("R10 tx queue flushed", v & 32'h8, 32'h8);

    // R10 flush mid-frame, both directions
    reg_wr(OFS_CTRL, 32'h14); reg_wr(OFS_DATA, 32'h0F); idle(30);
    reg_wr(OFS_CTRL, 32'h17);
    chk("R10 line high after flush", {31'b0, txd}, 32'h1);
    reg_rd(OFS_STAT, v); chk("R10 status after flush", v, 32'h00A);
    idle(150);
    reg_rd(OFS_STAT, v); chk("R10 no stray rx byte", v & 32'h2, 32'h2);

    // R10 receive flush
    reg_wr(OFS_DATA, 32'h44); reg_wr(OFS_DATA, 32'h55); idle(250);
    reg_rd(OFS_STAT, v); chk("R10 rx holds bytes", v & 32'h2, 32'h0);
    reg_wr(OFS_CTRL, 32'h15);
    reg_rd(OFS_STAT, v); chk("R10 rx queue flushed", v & 32'h2, 32'h2);

    // R7 transmit queue full
    reg_wr(OFS_CTRL, 32'h04);
    for (int i = 0; i < 65; i++) reg_wr(OFS_DATA, i);
    reg_rd(OFS_STAT, v); chk("R7 tx full flag", v & 32'h18, 32'h10);
    reg_wr(OFS_CTRL, 32'h14); idle(6700);
    reg_rd(OFS_STAT, v); chk("R3 rx full flag", v & 32'h6, 32'h4);
    for (int i = 0; i < 64; i++) begin
      reg_rd(OFS_DATA, v); chk($sformatf("R7 entry %0d", i), v, i);
    end
    reg_rd(OFS_STAT, v); chk("R7 extra byte dropped", v & 32'h2, 32'h2);

    // R8 receive queue full
    loop_en = 1'b0;
    reg_wr(OFS_CTRL, 32'h04);
    for (int i = 0; i < 66; i++) send_rx(8'(8'h40 + i));
    for (int i = 0; i < 64; i++) begin
      reg_rd(OFS_DATA, v); chk($sformatf("R8 entry %0d", i), v, 32'h40 + i);
    end
    reg_rd(OFS_STAT, v); chk("R8 overflow discarded", v & 32'h2, 32'h2);

    // R9 start glitch
    @(negedge clk); drv_rxd = 1'b0; idle(2); drv_rxd = 1'b1; idle(150);
    reg_rd(OFS_STAT, v); chk("R9 glitch rejected", v & 32'h2, 32'h2);
    send_rx(8'h3C);
    reg_rd(OFS_DATA, v); chk("R9 receiver still works", v, 32'h3C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule